// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a synchronous I2C target that presents a 256-byte byte-addressed memory to an external bus master. It samples the open-drain clock and data lines through a synchronizer running on the system clock, recognizes START and STOP conditions, and pulls the data line low only when it acknowledges a byte or returns a zero data bit. The bus side is modelled as open-drain: the block never drives the line high, and the bus is expected to pull it up.

A master stores a byte by sending the device select byte with the write flag, then one word address byte, then one data byte. To read, it first sends a write-flagged select byte and a word address to set the internal pointer. It then issues a repeated START with the read flag and clocks out bytes for as long as it acknowledges them. The pointer survives the repeated START and advances after every byte moved, wrapping from 255 to 0. Once a STOP closes a transfer that stored a byte, the block models the memory's internal programming time as a busy window of `WR_CYCLES` system clocks. During that window it refuses its own select byte, so a master can poll until it is acknowledged.

Top module: `i2c_eeprom_tgt`

## Requirements
- R1: While reset is asserted and directly after it, `sda_pull` is 0, so the data line is released.
- R2: SDA falling while SCL is high is a START; SDA rising while SCL is high is a STOP. After a STOP, bytes clocked without a new START are not acknowledged.
- R3: The select byte carries 4'hA in bits 7..4, the chip address in bits 3..1 and the direction in bit 0 (0 = write, 1 = read). The block acknowledges it during the ninth SCL pulse only when bits 7..4 are 4'hA and bits 3..1 equal `chip_sel`; otherwise SDA stays released (NACK).
- R4: In a write, the byte after the select byte is the word address and the next byte is stored at that address. The block acknowledges the select byte, the address byte and the data byte.
- R5: Any byte after the single data byte of a write is not acknowledged and is not stored.
- R6: After a write-flagged select byte and a word address, a repeated START with a read-flagged select byte returns the byte stored at that address, most significant bit first.
- R7: While the master acknowledges each read byte, the block sends the next one. The word pointer advances after each byte read or written and wraps from 255 to 0.
- R8: After the master answers a read byte with NACK, the block keeps SDA released until the next START.
- R9: For `WR_CYCLES` clocks after a STOP that ends a transfer which stored a byte, the block does not acknowledge its select byte. After the window it does again.
- R10: `sda_pull` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| chip_sel | input | 3 | Strapped chip address compared with select bits 3..1 |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
Every line change reaches the state register three system clocks after it occurs: two synchronizer stages plus the edge detector. `sda_pull` therefore moves in the fourth clock after an SCL fall. The bench master holds each SCL quarter phase for ten clocks and changes SDA only in the middle of the low phase. It samples the acknowledge and data bits in the middle of the high phase, so every result has settled well before it is read. Checks of the busy window are timed from the STOP: a poll issued right away is decided about 400 clocks later, inside the window, and a poll issued after waiting `WR_CYCLES` plus a margin falls outside it.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_WORDADDR,
    ST_WRDATA,
    ST_ACK,
    ST_TXBYTE,
    ST_MACK,
    ST_IGNORE
  } tgt_state_e;

  localparam logic [3:0] DEV_TYPE = 4'hA;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], din[g]};
    end

    assign dout[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/wr_busy_timer.sv
module wr_busy_timer #(
  parameter int CYCLES = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)             cnt_d = LOAD;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  AST_BUSY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R9
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD); // R9

endmodule

// File: rtl/byte_store.sv
module byte_store #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/i2c_eeprom_tgt.sv
module i2c_eeprom_tgt
  import i2c_eeprom_pkg::*;
#(
  parameter int WR_CYCLES   = 200000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] chip_sel,
  output logic       sda_pull
);

  localparam int WORD_W = 8;

  // line synchronizer and edge / condition detection
  logic [1:0] sync_out;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_i, sda_i}),
    .dout (sync_out)
  );
  assign scl_s = sync_out[1];
  assign sda_s = sync_out[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

  // protocol state
  tgt_state_e        state_q, state_d, ack_nxt_q, ack_nxt_d;
  logic [2:0]        bit_cnt_q, bit_cnt_d;
  logic [7:0]        shreg_q, shreg_d, txsh_q, txsh_d;
  logic [WORD_W-1:0] ptr_q, ptr_d;
  logic              byte_done_q, byte_done_d;
  logic              m_ack_q, m_ack_d;
  logic              wr_pend_q, wr_pend_d;
  logic              shift_en, mem_we, busy_start, busy, dev_match;
  logic [7:0]        rd_data;

  assign dev_match = (shreg_q[7:4] == DEV_TYPE) && (shreg_q[3:1] == chip_sel);

  always_comb begin
    state_d     = state_q;
    ack_nxt_d   = ack_nxt_q;
    bit_cnt_d   = bit_cnt_q;
    shreg_d     = shreg_q;
    txsh_d      = txsh_q;
    ptr_d       = ptr_q;
    byte_done_d = byte_done_q;
    m_ack_d     = m_ack_q;
    wr_pend_d   = wr_pend_q;
    shift_en    = 1'b0;
    mem_we      = 1'b0;
    busy_start  = 1'b0;
    if (stop_det) begin
      state_d    = ST_IDLE;
      busy_start = wr_pend_q;
      wr_pend_d  = 1'b0;
    end else if (start_det) begin
      state_d     = ST_DEVADDR;
      bit_cnt_d   = 3'd0;
      byte_done_d = 1'b0;
    end else begin
      case (state_q)
        ST_DEVADDR: begin
          if (scl_rise) shift_en = 1'b1;
          else if (scl_fall && byte_done_q) begin
            byte_done_d = 1'b0;
            if (dev_match && !busy) begin
              state_d = ST_ACK;
              if (shreg_q[0]) begin
                ack_nxt_d = ST_TXBYTE;
                txsh_d    = rd_data;
                ptr_d     = ptr_q + 1'b1;
              end else begin
                ack_nxt_d = ST_WORDADDR;
              end
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        ST_WORDADDR: begin
          if (scl_rise) shift_en = 1'b1;
          else if (scl_fall && byte_done_q) begin
            byte_done_d = 1'b0;
            ptr_d       = shreg_q[WORD_W-1:0];
            state_d     = ST_ACK;
            ack_nxt_d   = ST_WRDATA;
          end
        end
        ST_WRDATA: begin
          if (scl_rise) shift_en = 1'b1;
          else if (scl_fall && byte_done_q) begin
            byte_done_d = 1'b0;
            mem_we      = 1'b1;
            ptr_d       = ptr_q + 1'b1;
            wr_pend_d   = 1'b1;
            state_d     = ST_ACK;
            ack_nxt_d   = ST_IGNORE;
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state_d   = ack_nxt_q;
            bit_cnt_d = 3'd0;
          end
        end
        ST_TXBYTE: begin
          if (scl_fall) begin
            txsh_d    = {txsh_q[6:0], 1'b0};
            bit_cnt_d = bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) state_d = ST_MACK;
          end
        end
        ST_MACK: begin
          if (scl_rise) m_ack_d = ~sda_s;
          else if (scl_fall) begin
            if (m_ack_q) begin
              txsh_d    = rd_data;
              ptr_d     = ptr_q + 1'b1;
              bit_cnt_d = 3'd0;
              state_d   = ST_TXBYTE;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
      if (shift_en) begin
        shreg_d   = {shreg_q[6:0], sda_s};
        bit_cnt_d = bit_cnt_q + 3'd1;
        if (bit_cnt_q == 3'd7) byte_done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      ack_nxt_q   <= ST_IGNORE;
      bit_cnt_q   <= 3'd0;
      shreg_q     <= 8'd0;
      txsh_q      <= 8'd0;
      ptr_q       <= '0;
      byte_done_q <= 1'b0;
      m_ack_q     <= 1'b0;
      wr_pend_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      ack_nxt_q   <= ack_nxt_d;
      bit_cnt_q   <= bit_cnt_d;
      shreg_q     <= shreg_d;
      txsh_q      <= txsh_d;
      ptr_q       <= ptr_d;
      byte_done_q <= byte_done_d;
      m_ack_q     <= m_ack_d;
      wr_pend_q   <= wr_pend_d;
    end
  end

  assign sda_pull = (state_q == ST_ACK) | ((state_q == ST_TXBYTE) & ~txsh_q[7]);

  byte_store #(.AW(WORD_W)) u_store (
    .clk  (clk),
    .we   (mem_we),
    .waddr(ptr_q),
    .wdata(shreg_q),
    .raddr(ptr_q),
    .rdata(rd_data)
  );

  wr_busy_timer #(.CYCLES(WR_CYCLES)) u_busy (
    .clk  (clk),
    .rst_n(rst_n),
    .start(busy_start),
    .busy (busy)
  );

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE)); // R2
  AST_TYPE_MISMATCH_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEVADDR && byte_done_q && scl_fall && shreg_q[7:4] != DEV_TYPE)
      |=> (state_q != ST_ACK)); // R3
  AST_MNACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MACK && scl_fall && !m_ack_q) |=> !sda_pull); // R8
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state_q == ST_DEVADDR && byte_done_q && scl_fall)
      |=> (state_q == ST_IGNORE)); // R9
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> (!scl_s || $past(start_det) || $past(stop_det))); // R10

endmodule

// File: tb/tb_i2c_eeprom_tgt.sv
module tb_i2c_eeprom_tgt;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 10;
  localparam int WR_CYC     = 2000;
  localparam logic [2:0] MY_CHIP = 3'b101;

  typedef struct packed {
    logic       rd;
    logic [7:0] addr;
    logic [7:0] data;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h00, 8'h3C},
    '{1'b0, 8'h01, 8'hA5},
    '{1'b0, 8'hFF, 8'h81},
    '{1'b0, 8'h7E, 8'h00},
    '{1'b1, 8'h01, 8'h00},
    '{1'b1, 8'h00, 8'h00},
    '{1'b1, 8'hFF, 8'h00},
    '{1'b1, 8'h7E, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic pull;
  logic sda_bus;
  logic pull_prev = 1'b0;
  int   r10_bad = 0;
  int   checks = 0;
  int   fails = 0;
  logic [7:0] model [256];

  assign sda_bus = sda_m & ~pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_eeprom_tgt #(.WR_CYCLES(WR_CYC), .SYNC_STAGES(2)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_bus),
    .chip_sel(MY_CHIP),
    .sda_pull(pull)
  );

  // R10 monitor: any change of the pull output seen while the bus clock is high
  always @(posedge clk) begin
    if (rst_n && (pull !== pull_prev) && scl_m) r10_bad <= r10_bad + 1;
    pull_prev <= pull;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    waitc(QTR); sda_m = 1'b1;
    waitc(QTR); scl_m = 1'b1;
    waitc(2*QTR); sda_m = 1'b0;
    waitc(2*QTR); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    waitc(QTR); sda_m = 1'b0;
    waitc(QTR); scl_m = 1'b1;
    waitc(2*QTR); sda_m = 1'b1;
    waitc(2*QTR);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      waitc(QTR); sda_m = b[i];
      waitc(QTR); scl_m = 1'b1;
      waitc(2*QTR); scl_m = 1'b0;
    end
    waitc(QTR); sda_m = 1'b1;
    waitc(QTR); scl_m = 1'b1;
    waitc(QTR); acked = ~sda_bus;
    waitc(QTR); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitc(2*QTR); scl_m = 1'b1;
      waitc(QTR); b[i] = sda_bus;
      waitc(QTR); scl_m = 1'b0;
    end
    waitc(QTR); sda_m = give_ack ? 1'b0 : 1'b1;
    waitc(QTR); scl_m = 1'b1;
    waitc(2*QTR); scl_m = 1'b0;
  endtask

  task automatic eep_write(input logic [7:0] addr, input logic [7:0] data, output int nacks);
    bit a;
    nacks = 0;
    bus_start();
    send_byte({4'hA, MY_CHIP, 1'b0}, a); if (!a) nacks++;
    send_byte(addr, a); if (!a) nacks++;
    send_byte(data, a); if (!a) nacks++;
    bus_stop();
  endtask

  task automatic eep_read(input logic [7:0] addr, output logic [7:0] data, output int nacks);
    bit a;
    nacks = 0;
    bus_start();
    send_byte({4'hA, MY_CHIP, 1'b0}, a); if (!a) nacks++;
    send_byte(addr, a); if (!a) nacks++;
    bus_start();
    send_byte({4'hA, MY_CHIP, 1'b1}, a); if (!a) nacks++;
    recv_byte(1'b0, data);
    bus_stop();
  endtask

  initial begin
    int nk;
    bit a;
    logic [7:0] d;

    // R1: reset state
    waitc(5);
    check(pull === 1'b0, "R1 pull during reset", int'(pull), 0);
    rst_n = 1'b1;
    waitc(5);
    check(pull === 1'b0, "R1 pull after reset", int'(pull), 0);

    // table of writes and random reads
    for (int v = 0; v < NVEC; v++) begin
      if (!VECS[v].rd) begin
        eep_write(VECS[v].addr, VECS[v].data, nk);
        model[VECS[v].addr] = VECS[v].data;
        check(nk == 0, "R4 write acks", nk, 0);
        waitc(WR_CYC + 100);
      end else begin
        eep_read(VECS[v].addr, d, nk);
        check(nk == 0, "R6 read setup acks", nk, 0);
        check(d === model[VECS[v].addr], "R6 random read data", int'(d), int'(model[VECS[v].addr]));
      end
    end

    // R3: wrong chip bits and wrong type code are not acknowledged
    bus_start();
    send_byte({4'hA, 3'b001, 1'b0}, a);
    check(!a, "R3 chip mismatch NACK", int'(a), 0);
    bus_stop();
    bus_start();
    send_byte({4'hB, MY_CHIP, 1'b0}, a);
    check(!a, "R3 type mismatch NACK", int'(a), 0);
    bus_stop();
    bus_start();
    send_byte({4'hA, MY_CHIP, 1'b1}, a);
    check(a, "R3 matching select ACK", int'(a), 1);
    recv_byte(1'b0, d);
    bus_stop();

    // R2: after STOP, a byte clocked without START gets no acknowledge
    bus_start();
    send_byte({4'hA, MY_CHIP, 1'b0}, a);
    check(a, "R2 select ACK before stop", int'(a), 1);
    bus_stop();
    waitc(QTR); scl_m = 1'b0;
    send_byte({4'hA, MY_CHIP, 1'b0}, a);
    check(!a, "R2 no ACK without START", int'(a), 0);
    waitc(QTR); scl_m = 1'b1;
    waitc(2*QTR);

    // R9: busy window after a stored byte
    eep_write(8'h10, 8'h55, nk);
    model[8'h10] = 8'h55;
    bus_start();
    send_byte({4'hA, MY_CHIP, 1'b0}, a);
    check(!a, "R9 NACK while busy", int'(a), 0);
    bus_stop();
    waitc(WR_CYC + 100);
    bus_start();
    send_byte({4'hA, MY_CHIP, 1'b0}, a);
    check(a, "R9 ACK after busy", int'(a), 1);
    bus_stop();

    // R5: a second data byte is refused and not stored
    eep_write(8'h21, 8'h99, nk);
    model[8'h21] = 8'h99;
    waitc(WR_CYC + 100);
    bus_start();
    send_byte({4'hA, MY_CHIP, 1'b0}, a);
    send_byte(8'h20, a);
    send_byte(8'h11, a);
    check(a, "R5 first data ACK", int'(a), 1);
    send_byte(8'h22, a);
    check(!a, "R5 extra byte NACK", int'(a), 0);
    bus_stop();
    model[8'h20] = 8'h11;
    waitc(WR_CYC + 100);
    eep_read(8'h21, d, nk);
    check(d === 8'h99, "R5 neighbour unchanged", int'(d), 'h99);
    eep_read(8'h20, d, nk);
    check(d === 8'h11, "R5 stored byte", int'(d), 'h11);

    // R7 and R8: sequential read across the wrap, ended by NACK
    bus_start();
    send_byte({4'hA, MY_CHIP, 1'b0}, a);
    send_byte(8'hFF, a);
    bus_start();
    send_byte({4'hA, MY_CHIP, 1'b1}, a);
    recv_byte(1'b1, d);
    check(d === 8'h81, "R7 seq byte at FF", int'(d), 'h81);
    recv_byte(1'b1, d);
    check(d === 8'h3C, "R7 seq byte after wrap", int'(d), 'h3C);
    recv_byte(1'b0, d);
    check(d === 8'hA5, "R7 seq third byte", int'(d), 'hA5);
    sda_m = 1'b1;
    waitc(QTR);
    check(pull === 1'b0, "R8 released after NACK", int'(pull), 0);
    scl_m = 1'b1;
    waitc(QTR);
    check(sda_bus === 1'b1, "R8 line high after NACK", int'(sda_bus), 1);
    scl_m = 1'b0;
    bus_stop();

    // R10: output moved only while the bus clock was low
    check(r10_bad == 0, "R10 pull changes with SCL high", r10_bad, 0);

    summary();
    $finish;
  end

endmodule